// File: doc/BRIEF.md
# Trap Condition and Interrupt Entry Unit

This is a purely combinational execute-stage unit in a 64-bit processor. It handles conditional trap instructions and system calls. For a conditional trap it compares two register operands five ways: signed and unsigned ordering, plus equality. A word-mode input selects between full 64-bit operands and the low 32 bits of each. The five results are gated by a 5-bit condition mask taken from the instruction. A separate forced-cause vector, raised by earlier stages for floating-point, privileged, address or illegal faults, makes the trap unconditional.

When an entry happens, the unit produces four values, each with a valid strobe: the next machine state word, the two save/restore words (return address and saved state with cause bits), and the redirected fetch address. A trap entry and a system-call entry follow the same state-word rewrite. They differ in the saved return address and in the cause bits. When no entry happens, every strobe is low and every data output is zero.

All bit numbers in the requirements use MSB-0 numbering, so bit 0 is the most significant bit of a 64-bit word and bit 63 is the least significant. The operation select `op_kind` is encoded as 2'b00 idle, 2'b01 conditional trap, 2'b10 system call and 2'b11 idle.

Top module: `trap_entry_unit`

## Requirements
- R1: In 64-bit mode the condition vector, from its LSB (bit 0 of `cond_mask`) to its MSB, is: unsigned a>b, unsigned a<b, a==b, signed a>b, signed a<b, all computed over the full 64-bit operands.
- R2: With `is_word` high, the signed comparisons use the low 32 bits of each operand sign-extended, and the unsigned comparisons and equality use the low 32 bits zero-extended. The upper 32 bits of the operands have no effect.
- R3: A conditional trap is taken when any bit of `force_type` is set, or when the condition vector ANDed with `cond_mask` is nonzero. Otherwise no entry happens.
- R4: On any entry, `msr_nxt` is `cur_msr` with bits 5, 29, 30, 31, 38, 40, 48, 49, 50, 52, 55, 58, 59, 61 and 62 cleared and bits 0 and 63 set.
- R5: On a trap entry, `srr0_nxt` equals `cur_pc`.
- R6: On a trap entry, `srr1_nxt` is `cur_msr` with these changes: bits 33..36 and 42 are cleared. Bit 43 takes `force_type[0]`, bit 44 takes `force_type[4]`, bit 45 takes `force_type[1]` and bit 47 takes `force_type[3]`. Bit 46 is 1 exactly when `force_type` is all zero. `force_type[2]` is not recorded.
- R7: On any entry, `nia_nxt` equals `vec_offset` zero-extended and shifted left by 4.
- R8: On a system call, `srr0_nxt` equals `cur_pc + 4` modulo 2^64.
- R9: On a system call, `srr1_nxt` is `cur_msr` with bits 33..36 and 42..47 cleared.
- R10: With no entry (idle op, or a trap whose condition fails), `entry_taken` and all four valid strobes are 0 and all four data outputs are 0. With an entry, all of them are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_kind | input | 2 | 00 idle, 01 conditional trap, 10 system call, 11 idle |
| is_word | input | 1 | Compare the low 32 bits only |
| opnd_a | input | 64 | First compare operand |
| opnd_b | input | 64 | Second compare operand |
| cond_mask | input | 5 | Condition mask from the instruction |
| force_type | input | 5 | Forced cause: [0] float, [1] privileged, [3] address, [4] illegal |
| cur_msr | input | 64 | Current machine state word |
| cur_pc | input | 64 | Address of the current instruction |
| vec_offset | input | 12 | Entry vector offset, in units of 16 bytes |
| entry_taken | output | 1 | An entry happens this cycle |
| msr_nxt | output | 64 | New machine state word |
| msr_vld | output | 1 | `msr_nxt` is to be written |
| srr0_nxt | output | 64 | Saved return address |
| srr0_vld | output | 1 | `srr0_nxt` is to be written |
| srr1_nxt | output | 64 | Saved state with cause bits |
| srr1_vld | output | 1 | `srr1_nxt` is to be written |
| nia_nxt | output | 64 | Redirected fetch address |
| nia_vld | output | 1 | `nia_nxt` is to be taken |

## Verification
The assertions expect all inputs to settle to known values before they are evaluated. They also expect that the reserved op code 2'b11 behaves as idle, so no entry property ever covers it. The checks on mutual exclusion of the compare results rely on the operands being stable within an evaluation. The bench makes sure of this by changing inputs only just after a clock edge and reading outputs at the opposite edge.

The bench drives the reserved op code only in the idle scenario. Its cause vectors cover each single cause, the all-zero vector and a multi-bit vector. Its operands include values that differ only in the upper word, so the word-mode rule is tested against the full-width rule.

// File: rtl/trap_pkg.sv
package trap_pkg;

   localparam int XLEN = 64;

   typedef enum logic [1:0] {
      OPK_IDLE  = 2'b00,
      OPK_TRAP  = 2'b01,
      OPK_SCALL = 2'b10,
      OPK_RSVD  = 2'b11
   } opkind_e;

   // condition vector positions (LSB first)
   localparam int CND_GTU = 0;
   localparam int CND_LTU = 1;
   localparam int CND_EQ  = 2;
   localparam int CND_GTS = 3;
   localparam int CND_LTS = 4;
   localparam int NCOND   = 5;

   // forced cause positions
   localparam int TY_FLT  = 0;
   localparam int TY_PRIV = 1;
   localparam int TY_ADDR = 3;
   localparam int TY_ILL  = 4;
   localparam int NTYPE   = 5;

   // MSB-0 bit number to vector index
   function automatic int lsb_idx(input int msb0);
      return XLEN - 1 - msb0;
   endfunction

   // state-word bits cleared on entry, MSB-0 numbering
   localparam int NCLR = 15;
   localparam int CLR_BITS [NCLR] = '{5, 29, 30, 31, 38, 40, 48, 49, 50,
                                      52, 55, 58, 59, 61, 62};

   function automatic logic [XLEN-1:0] entry_clr_mask();
      logic [XLEN-1:0] m;
      m = '0;
      for (int i = 0; i < NCLR; i++) m[lsb_idx(CLR_BITS[i])] = 1'b1;
      return m;
   endfunction

   function automatic logic [XLEN-1:0] entry_set_mask();
      logic [XLEN-1:0] m;
      m = '0;
      m[lsb_idx(0)]  = 1'b1;   // 64-bit mode
      m[lsb_idx(63)] = 1'b1;   // little-endian
      return m;
   endfunction

   // SRR1 field clears, MSB-0 ranges [lo..hi]
   function automatic logic [XLEN-1:0] range_mask(input int lo, input int hi);
      logic [XLEN-1:0] m;
      m = '0;
      for (int b = lo; b <= hi; b++) m[lsb_idx(b)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/trap_cmp.sv
module trap_cmp
   import trap_pkg::*;
#(
   parameter int W    = 64,
   parameter int HALF = 32
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic             word_mode,
   output logic [NCOND-1:0] cvec
);
   logic [W-1:0] a_z, b_z, a_s, b_s;

   generate
      if (HALF > W || HALF < 1) begin : g_bad_half
         $error("trap_cmp: HALF must lie in 1..W");
      end
      if (HALF < W) begin : g_narrow
         always_comb begin
            if (word_mode) begin
               a_z = {{(W-HALF){1'b0}}, a[HALF-1:0]};
               b_z = {{(W-HALF){1'b0}}, b[HALF-1:0]};
               a_s = {{(W-HALF){a[HALF-1]}}, a[HALF-1:0]};
               b_s = {{(W-HALF){b[HALF-1]}}, b[HALF-1:0]};
            end else begin
               a_z = a;
               b_z = b;
               a_s = a;
               b_s = b;
            end
         end
      end else begin : g_full
         assign a_z = a;
         assign b_z = b;
         assign a_s = a;
         assign b_s = b;
      end
   endgenerate

   always_comb begin
      cvec          = '0;
      cvec[CND_GTU] = a_z > b_z;
      cvec[CND_LTU] = a_z < b_z;
      cvec[CND_EQ]  = a_z == b_z;
      cvec[CND_GTS] = $signed(a_s) > $signed(b_s);
      cvec[CND_LTS] = $signed(a_s) < $signed(b_s);
   end

   // R1: exactly one ordering holds in each domain; equality agrees in both
   always_comb begin
      a_r1_unsigned_onehot : assert ($countones({cvec[CND_GTU], cvec[CND_LTU], cvec[CND_EQ]}) == 1)
         else $error("unsigned compare outcome not one-hot");
      a_r1_signed_onehot : assert ($countones({cvec[CND_GTS], cvec[CND_LTS], cvec[CND_EQ]}) == 1)
         else $error("signed compare outcome not one-hot");
   end

endmodule

// File: rtl/trap_msr_rw.sv
module trap_msr_rw
   import trap_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] msr_cur,
   output logic [W-1:0] msr_new
);
   localparam logic [W-1:0] CLR = entry_clr_mask();
   localparam logic [W-1:0] SET = entry_set_mask();

   generate
      if (W != XLEN) begin : g_bad_w
         $error("trap_msr_rw: W must equal XLEN");
      end
   endgenerate

   assign msr_new = (msr_cur & ~CLR) | SET;

   // R4: mode bits forced, machine-check enable and hypervisor bits kept
   always_comb begin
      a_r4_mode_bits_set : assert (msr_new[lsb_idx(0)] && msr_new[lsb_idx(63)])
         else $error("entry state word lost 64-bit or LE bit");
      a_r4_kept_bits : assert (msr_new[lsb_idx(51)] == msr_cur[lsb_idx(51)]
                               && msr_new[lsb_idx(3)] == msr_cur[lsb_idx(3)])
         else $error("entry state word altered a preserved bit");
   end

endmodule

// File: rtl/trap_srr1.sv
module trap_srr1
   import trap_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0]     msr_cur,
   input  logic [NTYPE-1:0] ftype,
   input  logic             scall,
   output logic [W-1:0]     srr1
);
   localparam logic [W-1:0] CLR_TRAP  = range_mask(33, 36) | range_mask(42, 42);
   localparam logic [W-1:0] CLR_SCALL = range_mask(33, 36) | range_mask(42, 47);

   logic [W-1:0] cause;

   always_comb begin
      cause = '0;
      cause[lsb_idx(43)] = ftype[TY_FLT];
      cause[lsb_idx(44)] = ftype[TY_ILL];
      cause[lsb_idx(45)] = ftype[TY_PRIV];
      cause[lsb_idx(46)] = ~|ftype;
      cause[lsb_idx(47)] = ftype[TY_ADDR];
      if (scall) srr1 = msr_cur & ~CLR_SCALL;
      else       srr1 = (msr_cur & ~range_mask(33, 47)) | (msr_cur & range_mask(37, 41)) | cause;
   end

   // R6 / R9: cause field content
   always_comb begin
      a_r9_scall_cause_zero : assert (!scall || srr1[lsb_idx(42):lsb_idx(47)] == '0)
         else $error("system call recorded a cause bit");
      a_r6_plain_trap_flag : assert (scall || ((ftype == '0) == srr1[lsb_idx(46)]))
         else $error("plain trap flag disagrees with cause vector");
      a_r6_no_bad_thing : assert (scall || !srr1[lsb_idx(42)])
         else $error("bit 42 set on trap entry");
   end

   logic unused_clr;
   assign unused_clr = ^CLR_TRAP;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_pkg::*;
#(
   parameter int W      = 64,
   parameter int HALF   = 32,
   parameter int VOFF_W = 12,
   parameter int VSHIFT = 4
) (
   input  logic [1:0]       op_kind,
   input  logic             is_word,
   input  logic [W-1:0]     opnd_a,
   input  logic [W-1:0]     opnd_b,
   input  logic [4:0]       cond_mask,
   input  logic [4:0]       force_type,
   input  logic [W-1:0]     cur_msr,
   input  logic [W-1:0]     cur_pc,
   input  logic [VOFF_W-1:0] vec_offset,
   output logic             entry_taken,
   output logic [W-1:0]     msr_nxt,
   output logic             msr_vld,
   output logic [W-1:0]     srr0_nxt,
   output logic             srr0_vld,
   output logic [W-1:0]     srr1_nxt,
   output logic             srr1_vld,
   output logic [W-1:0]     nia_nxt,
   output logic             nia_vld
);
   localparam int           PAD      = W - VOFF_W - VSHIFT;
   localparam logic [W-1:0] PC_STEP  = W'(4);

   generate
      if (PAD < 0) begin : g_bad_voff
         $error("trap_entry_unit: VOFF_W + VSHIFT exceeds W");
      end
      if (W != XLEN) begin : g_bad_w
         $error("trap_entry_unit: W must equal XLEN");
      end
   endgenerate

   opkind_e          kind;
   logic [NCOND-1:0] cvec;
   logic [W-1:0]     msr_rw, srr1_raw;
   logic             is_trap, is_scall, trap_hit;

   assign kind     = opkind_e'(op_kind);
   assign is_trap  = (kind == OPK_TRAP);
   assign is_scall = (kind == OPK_SCALL);

   trap_cmp #(.W(W), .HALF(HALF)) u_cmp (
      .a         (opnd_a),
      .b         (opnd_b),
      .word_mode (is_word),
      .cvec      (cvec)
   );

   trap_msr_rw #(.W(W)) u_msr (
      .msr_cur (cur_msr),
      .msr_new (msr_rw)
   );

   trap_srr1 #(.W(W)) u_srr1 (
      .msr_cur (cur_msr),
      .ftype   (force_type),
      .scall   (is_scall),
      .srr1    (srr1_raw)
   );

   assign trap_hit    = is_trap && ((|force_type) || (|(cvec & cond_mask)));
   assign entry_taken = trap_hit || is_scall;

   always_comb begin
      msr_vld  = entry_taken;
      srr0_vld = entry_taken;
      srr1_vld = entry_taken;
      nia_vld  = entry_taken;
      msr_nxt  = '0;
      srr0_nxt = '0;
      srr1_nxt = '0;
      nia_nxt  = '0;
      if (entry_taken) begin
         msr_nxt  = msr_rw;
         srr0_nxt = is_scall ? cur_pc + PC_STEP : cur_pc;
         srr1_nxt = srr1_raw;
         nia_nxt  = {{(W-VOFF_W){1'b0}}, vec_offset} << VSHIFT;
      end
   end

   always_comb begin
      // R3: a forced cause always enters; idle never does
      a_r3_forced_enters : assert (!(is_trap && force_type != '0) || entry_taken)
         else $error("forced cause did not enter");
      a_r3_idle_quiet : assert (is_trap || is_scall || !entry_taken)
         else $error("entry without trap or system call");
      // R10: strobes move together, data zero when quiet
      a_r10_strobes_agree : assert ((msr_vld == srr0_vld) && (srr1_vld == nia_vld) && (msr_vld == srr1_vld))
         else $error("valid strobes disagree");
      a_r10_quiet_zero : assert (msr_vld || (msr_nxt == '0 && srr0_nxt == '0 && srr1_nxt == '0 && nia_nxt == '0))
         else $error("data driven without a valid strobe");
      // R7: redirect is 16-byte aligned
      a_r7_nia_aligned : assert (nia_nxt[VSHIFT-1:0] == '0)
         else $error("redirect address not aligned");
   end

endmodule

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [1:0]  op_kind;
   logic        is_word;
   logic [63:0] opnd_a, opnd_b, cur_msr, cur_pc;
   logic [4:0]  cond_mask, force_type;
   logic [11:0] vec_offset;
   logic        entry_taken, msr_vld, srr0_vld, srr1_vld, nia_vld;
   logic [63:0] msr_nxt, srr0_nxt, srr1_nxt, nia_nxt;

   int n_chk = 0;
   int n_bad = 0;

   trap_entry_unit dut_i (
      .op_kind(op_kind), .is_word(is_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .cond_mask(cond_mask), .force_type(force_type), .cur_msr(cur_msr),
      .cur_pc(cur_pc), .vec_offset(vec_offset), .entry_taken(entry_taken),
      .msr_nxt(msr_nxt), .msr_vld(msr_vld), .srr0_nxt(srr0_nxt), .srr0_vld(srr0_vld),
      .srr1_nxt(srr1_nxt), .srr1_vld(srr1_vld), .nia_nxt(nia_nxt), .nia_vld(nia_vld)
   );

   function automatic int bx(input int msb0);
      return 63 - msb0;
   endfunction

   function automatic logic [63:0] m_msr(input logic [63:0] m);
      logic [63:0] r = m;
      int cl [15] = '{62, 61, 59, 58, 55, 52, 50, 49, 48, 40, 38, 31, 30, 29, 5};
      foreach (cl[i]) r[bx(cl[i])] = 1'b0;
      r[bx(0)] = 1'b1;
      r[bx(63)] = 1'b1;
      return r;
   endfunction

   function automatic logic [63:0] m_srr1_trap(input logic [63:0] m, input logic [4:0] t);
      logic [63:0] r = m;
      for (int b = 33; b <= 36; b++) r[bx(b)] = 1'b0;
      r[bx(42)] = 1'b0;
      r[bx(43)] = t[0];
      r[bx(44)] = t[4];
      r[bx(45)] = t[1];
      r[bx(46)] = (t == 5'd0);
      r[bx(47)] = t[3];
      return r;
   endfunction

   function automatic logic [63:0] m_srr1_sc(input logic [63:0] m);
      logic [63:0] r = m;
      for (int b = 33; b <= 36; b++) r[bx(b)] = 1'b0;
      for (int b = 42; b <= 47; b++) r[bx(b)] = 1'b0;
      return r;
   endfunction

   function automatic logic [4:0] m_cond(input logic [63:0] a, input logic [63:0] b, input logic w);
      logic [63:0] az, bz;
      logic signed [63:0] as_, bs_;
      if (w) begin
         az = {32'd0, a[31:0]};
         bz = {32'd0, b[31:0]};
         as_ = {{32{a[31]}}, a[31:0]};
         bs_ = {{32{b[31]}}, b[31:0]};
      end else begin
         az = a; bz = b; as_ = a; bs_ = b;
      end
      return {as_ < bs_, as_ > bs_, az == bz, az < bz, az > bz};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply();
      @(negedge clk);
   endtask

   task automatic drive(input logic [1:0] k, input logic w, input logic [63:0] a,
                        input logic [63:0] b, input logic [4:0] cm, input logic [4:0] ft);
      @(posedge clk);
      #1;
      op_kind = k; is_word = w; opnd_a = a; opnd_b = b; cond_mask = cm; force_type = ft;
      apply();
   endtask

   task automatic check_quiet(input string req);
      chk(req, {entry_taken, msr_vld, srr0_vld, srr1_vld, nia_vld}, 64'd0);
      chk(req, msr_nxt | srr0_nxt | srr1_nxt | nia_nxt, 64'd0);
   endtask

   task automatic check_trap_entry(input string req);
      chk({req, " R10 strobes"}, {entry_taken, msr_vld, srr0_vld, srr1_vld, nia_vld}, 64'h1f);
      chk("R4 msr", msr_nxt, m_msr(cur_msr));
      chk("R5 srr0", srr0_nxt, cur_pc);
      chk("R6 srr1", srr1_nxt, m_srr1_trap(cur_msr, force_type));
      chk("R7 nia", nia_nxt, {48'd0, vec_offset, 4'd0});
   endtask

   // R10: idle and reserved op codes are quiet whatever the operands
   task automatic t_idle();
      drive(2'b00, 1'b0, 64'd5, 64'd5, 5'h1f, 5'h1f);
      check_quiet("R10 idle");
      drive(2'b11, 1'b0, 64'd5, 64'd5, 5'h1f, 5'h1f);
      check_quiet("R10 reserved");
   endtask

   // R1: each single mask bit against the reference compare, full width
   task automatic t_cmp64();
      logic [63:0] pa [4] = '{64'h8000_0000_0000_0000, 64'd7, 64'd3, 64'hffff_ffff_ffff_fffe};
      logic [63:0] pb [4] = '{64'd1, 64'd7, 64'd9, 64'hffff_ffff_ffff_ffff};
      for (int p = 0; p < 4; p++) begin
         for (int c = 0; c < 5; c++) begin
            logic [4:0] e;
            drive(2'b01, 1'b0, pa[p], pb[p], 5'(1 << c), 5'd0);
            e = m_cond(pa[p], pb[p], 1'b0);
            chk("R1 cond bit", {63'd0, entry_taken}, {63'd0, e[c]});
         end
      end
   endtask

   // R2: word mode ignores upper halves, sign from bit 31
   task automatic t_cmp32();
      logic [63:0] a = 64'h0000_0001_8000_0000;
      logic [63:0] b = 64'hffff_fff0_0000_0001;
      for (int c = 0; c < 5; c++) begin
         logic [4:0] e;
         drive(2'b01, 1'b1, a, b, 5'(1 << c), 5'd0);
         e = m_cond(a, b, 1'b1);
         chk("R2 word cond bit", {63'd0, entry_taken}, {63'd0, e[c]});
      end
      drive(2'b01, 1'b1, 64'h1234_0000_0000_0009, 64'h0000_5678_0000_0009, 5'b00100, 5'd0);
      chk("R2 word equal", {63'd0, entry_taken}, 64'd1);
      drive(2'b01, 1'b0, 64'h1234_0000_0000_0009, 64'h0000_5678_0000_0009, 5'b00100, 5'd0);
      chk("R1 full not equal", {63'd0, entry_taken}, 64'd0);
   endtask

   // R3: failing condition is quiet; any forced cause enters
   task automatic t_force();
      drive(2'b01, 1'b0, 64'd3, 64'd3, 5'b11011, 5'd0);
      check_quiet("R3 cond fail");
      for (int t = 0; t < 5; t++) begin
         drive(2'b01, 1'b0, 64'd3, 64'd3, 5'd0, 5'(1 << t));
         check_trap_entry("R3 forced");
      end
      drive(2'b01, 1'b0, 64'd3, 64'd3, 5'd0, 5'b11011);
      check_trap_entry("R3 multi forced");
   endtask

   // R4..R7 with a plain conditional trap and varied state words
   task automatic t_trap_entry();
      cur_msr = 64'hffff_ffff_ffff_ffff; cur_pc = 64'h0000_0000_1000_2000; vec_offset = 12'h070;
      drive(2'b01, 1'b0, 64'd1, 64'd2, 5'b00010, 5'd0);
      check_trap_entry("R6 plain");
      cur_msr = 64'h0123_4567_89ab_cdef; vec_offset = 12'hfff;
      drive(2'b01, 1'b0, 64'd1, 64'd2, 5'b10000, 5'd0);
      check_trap_entry("R7 max offset");
   endtask

   // R8, R9 system call, including address wrap
   task automatic t_scall();
      cur_msr = 64'hffff_ffff_ffff_ffff; cur_pc = 64'h0000_0000_0000_0100; vec_offset = 12'h0c0;
      drive(2'b10, 1'b0, 64'd0, 64'd0, 5'd0, 5'b11111);
      chk("R10 scall strobes", {entry_taken, msr_vld, srr0_vld, srr1_vld, nia_vld}, 64'h1f);
      chk("R8 srr0", srr0_nxt, 64'h104);
      chk("R9 srr1", srr1_nxt, m_srr1_sc(cur_msr));
      chk("R4 scall msr", msr_nxt, m_msr(cur_msr));
      chk("R7 scall nia", nia_nxt, 64'hc00);
      cur_pc = 64'hffff_ffff_ffff_fffc; cur_msr = 64'h5a5a_a5a5_0f0f_f0f0;
      drive(2'b10, 1'b0, 64'd0, 64'd0, 5'd0, 5'd0);
      chk("R8 wrap", srr0_nxt, 64'd0);
      chk("R9 srr1 pattern", srr1_nxt, m_srr1_sc(cur_msr));
   endtask

   initial begin
      op_kind = 2'b00; is_word = 1'b0; opnd_a = '0; opnd_b = '0;
      cond_mask = '0; force_type = '0; cur_msr = '0; cur_pc = '0; vec_offset = '0;
      apply();
      check_quiet("R10 initial");
      t_idle();
      cur_msr = 64'h8000_0000_0000_1001; cur_pc = 64'h40; vec_offset = 12'h07;
      t_cmp64();
      t_cmp32();
      t_force();
      t_trap_entry();
      t_scall();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule